// File: doc/BRIEF.md
# RC5-32 First-Pass Key Mixing Pipeline

This block feeds a brute-force key search. It holds a 64-bit candidate-key counter and issues one new candidate into a deep pipeline on every accepted cycle. The pipeline runs the first pass of the RC5-32 key-expansion mixing loop. Each stage performs one step: it produces one new S word through a fixed 3-bit left rotate, then updates one of the two L words through a left rotate whose amount comes from the data. Any term that does not depend on the key is folded into a constant when the design is elaborated. The second and third passes and the cipher rounds belong to a later block that takes this block's outputs.

A `start_i` pulse loads a base key into the counter. While `enable_i` is high, each cycle in which neither `start_i` nor `stall_i` is high issues the current counter value and then increments the counter. `stall_i` freezes the counter and every pipeline stage. When the last stage holds a result, `valid_o` is high and the outputs carry the 26 mixed S words and the final L0 and L1 words for that key.

Top module: `rc5_keysched_pass1`

## Requirements
- R1: After reset, `valid_o` is low and stays low until a key has crossed the whole pipeline.
- R2: A cycle with `start_i` high loads `base_key_i` into the counter and issues no key, even when `stall_i` or `enable_i` is high. The next key issued is `base_key_i`.
- R3: A cycle with `enable_i` high and `start_i` and `stall_i` low issues the current counter value, and the counter then advances by one, wrapping from all-ones to zero.
- R4: For an issued key, L0 starts as key bits [31:0] and L1 starts as key bits [63:32].
- R5: S word 0 is the constant 0xBF0A8B1D, which is 0xB7E15163 rotated left by 3. The first L0 update rotates by that constant's low 5 bits.
- R6: For k from 1 to NUM_STEPS-1, S word k equals ROTL3(M_k + S_(k-1) + L_recent), where M_k = 0xB7E15163 + k*0x9E3779B9 mod 2^32 and L_recent is the L word updated in step k-1. All sums wrap mod 2^32.
- R7: Step k updates L word (k mod 2), so the last default step (25) updates L1. The update is L = ROTL(L + S_k + L_other, S_k + L_other), where L_other is the other L word and only the low 5 bits of the amount are used. `l0_o` and `l1_o` carry both L words after the last step.
- R8: A key's results appear with `valid_o` high after the NUM_STEPS-th unstalled rising edge, counting the edge that issues it. Results leave in issue order.
- R9: While `stall_i` is high, the counter, `valid_o` and every data output hold their values.
- R10: A cycle with `enable_i` low issues nothing and holds the counter, and it later shows up as a cycle with `valid_o` low.
- R11: `s_words_o` packs S word k into bits [32k+31:32k].

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| start_i | input | 1 | Load `base_key_i` into the key counter |
| base_key_i | input | 64 | Base candidate key |
| enable_i | input | 1 | Issue keys while high |
| stall_i | input | 1 | Freeze the counter and the whole pipeline |
| valid_o | output | 1 | The outputs hold a finished first pass |
| s_words_o | output | NUM_STEPS*32 | Mixed S words, word k at bits [32k+31:32k] |
| l0_o | output | 32 | Final L0 word |
| l1_o | output | 32 | Final L1 word |

## Verification
On every cycle, the assertions check how the counter responds to load, advance and hold. They also check that each stage's valid bit moves only on unstalled edges, that a stalled stage keeps all of its outputs, that the L word a stage does not touch passes through unchanged, that earlier S words are carried forward, and that the output S word 0 equals its hard-wired value. Only the bench's scenarios can show that the mixed S and L values are correct for real keys. The bench compares against an independent model of the key schedule, using the all-zero key, the all-ones key with counter wrap, and random keys issued under random enable, stall and restart patterns. Those scenarios are also the only way to show the end-to-end latency and ordering.

// File: rtl/rc5ks_pkg.sv
`timescale 1ns/1ps
package rc5ks_pkg;

  localparam int unsigned WORD_W = 32;
  localparam int unsigned ROT_W  = 5;
  localparam int unsigned KEY_W  = 2 * WORD_W;

  typedef logic [WORD_W-1:0] word_t;

  localparam word_t MAGIC_BASE = 32'hB7E15163;
  localparam word_t MAGIC_INC  = 32'h9E3779B9;

  // Initial table word for step idx, wrapping mod 2^32
  function automatic word_t magic_word(input int unsigned idx);
    word_t k;
    k = word_t'(idx);
    return MAGIC_BASE + k * MAGIC_INC;
  endfunction

  // Fixed left rotate by three: pure wiring
  function automatic word_t rotl_fixed3(input word_t x);
    return {x[WORD_W-4:0], x[WORD_W-1:WORD_W-3]};
  endfunction

  // Left rotate by a 5-bit amount through a doubled word
  function automatic word_t rotl_var(input word_t x, input logic [ROT_W-1:0] amt);
    logic [2*WORD_W-1:0] dbl;
    dbl = {x, x} << amt;
    return dbl[2*WORD_W-1:WORD_W];
  endfunction

  // The first S word never depends on the key
  localparam word_t S_FIRST = rotl_fixed3(MAGIC_BASE);

endpackage

// File: rtl/rc5ks_key_ctr.sv
`timescale 1ns/1ps
module rc5ks_key_ctr
  import rc5ks_pkg::*;
#(
  parameter int unsigned CTR_W = KEY_W
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             start_i,
  input  logic [CTR_W-1:0] base_key_i,
  input  logic             enable_i,
  input  logic             stall_i,
  output logic [CTR_W-1:0] key_o,
  output logic             issue_o
);

  logic [CTR_W-1:0] key_q;
  logic [CTR_W-1:0] key_d;
  logic             key_en;

  // Next state: load has priority, otherwise advance on an accepted cycle
  always_comb begin
    issue_o = enable_i & ~start_i & ~stall_i;
    key_en  = start_i | issue_o;
    key_d   = start_i ? base_key_i : key_q + CTR_W'(1);
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      key_q <= '0;
    end else if (key_en) begin
      key_q <= key_d;
    end
  end

  assign key_o = key_q;

  AST_CTR_LOAD: assert property (@(posedge clk) disable iff (!rst_n)
    start_i |=> key_o == $past(base_key_i)); // R2

  AST_CTR_STEP: assert property (@(posedge clk) disable iff (!rst_n)
    (enable_i && !start_i && !stall_i) |=> key_o == $past(key_o) + CTR_W'(1)); // R3

  AST_CTR_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
    (!start_i && (stall_i || !enable_i)) |=> $stable(key_o)); // R9

endmodule

// File: rtl/rc5ks_mix_stage.sv
`timescale 1ns/1ps
module rc5ks_mix_stage
  import rc5ks_pkg::*;
#(
  parameter int unsigned STEP      = 0,
  parameter int unsigned NUM_STEPS = 26
) (
  input  logic                        clk,
  input  logic                        rst_n,
  input  logic                        adv_i,
  input  logic                        valid_i,
  input  logic [NUM_STEPS*WORD_W-1:0] s_i,
  input  word_t                       l0_i,
  input  word_t                       l1_i,
  output logic                        valid_o,
  output logic [NUM_STEPS*WORD_W-1:0] s_o,
  output word_t                       l0_o,
  output word_t                       l1_o
);

  localparam int unsigned UPD     = STEP % 2;
  localparam word_t       MAGIC_K = magic_word(STEP);
  localparam word_t       FOLD_K  = (STEP == 1) ? MAGIC_K + S_FIRST : MAGIC_K;
  localparam logic [ROT_W-1:0] ROT_FIRST = S_FIRST[ROT_W-1:0];

  word_t s_new;
  word_t l_upd;
  word_t l_mine;
  word_t l_other;
  word_t l0_d;
  word_t l1_d;
  logic  load;
  logic  valid_q;
  word_t l0_q;
  word_t l1_q;
  logic  stage_unused;

  assign stage_unused = ^s_i;

  // The L word touched by this step, and the one updated just before it
  always_comb begin
    l_mine  = (UPD == 1) ? l1_i : l0_i;
    l_other = (UPD == 1) ? l0_i : l1_i;
  end

  generate
    if (STEP == 0) begin : g_first
      // No key-dependent term: S is wired, the rotate amount is static
      always_comb begin
        s_new = S_FIRST;
        l_upd = rotl_var(l_mine + S_FIRST, ROT_FIRST);
      end
    end else if (STEP == 1) begin : g_second
      // Previous S is the constant, already folded into FOLD_K
      word_t mix;
      always_comb begin
        s_new = rotl_fixed3(FOLD_K + l_other);
        mix   = s_new + l_other;
        l_upd = rotl_var(l_mine + mix, mix[ROT_W-1:0]);
      end
    end else begin : g_general
      word_t s_prev;
      word_t mix;
      always_comb begin
        s_prev = s_i[(STEP-1)*WORD_W +: WORD_W];
        s_new  = rotl_fixed3(FOLD_K + s_prev + l_other);
        mix    = s_new + l_other;
        l_upd  = rotl_var(l_mine + mix, mix[ROT_W-1:0]);
      end
    end
  endgenerate

  // Next state for the L pair
  always_comb begin
    load = adv_i & valid_i;
    l0_d = (UPD == 0) ? l_upd : l0_i;
    l1_d = (UPD == 1) ? l_upd : l1_i;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      valid_q <= 1'b0;
    end else if (adv_i) begin
      valid_q <= valid_i;
    end
  end

  always_ff @(posedge clk) begin
    if (load) begin
      l0_q <= l0_d;
      l1_q <= l1_d;
    end
  end

  // S array: word 0 wired, words up to STEP stored, later words zero
  assign s_o[WORD_W-1:0] = S_FIRST;

  generate
    for (genvar w = 1; w < NUM_STEPS; w++) begin : g_word
      if (w < STEP) begin : g_carry
        word_t carry_q;
        always_ff @(posedge clk) begin
          if (load) carry_q <= s_i[w*WORD_W +: WORD_W];
        end
        assign s_o[w*WORD_W +: WORD_W] = carry_q;
      end else if (w == STEP) begin : g_fresh
        word_t fresh_q;
        always_ff @(posedge clk) begin
          if (load) fresh_q <= s_new;
        end
        assign s_o[w*WORD_W +: WORD_W] = fresh_q;
      end else begin : g_empty
        assign s_o[w*WORD_W +: WORD_W] = '0;
      end
    end
  endgenerate

  assign valid_o = valid_q;
  assign l0_o    = l0_q;
  assign l1_o    = l1_q;

  AST_STAGE_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
    !adv_i |=> $stable(valid_o) && $stable(s_o) && $stable(l0_o) && $stable(l1_o)); // R9

  AST_STAGE_FLOW: assert property (@(posedge clk) disable iff (!rst_n)
    adv_i |=> valid_o == $past(valid_i)); // R8

  generate
    if (UPD == 0) begin : g_chk_l1
      AST_OTHER_L_PASS: assert property (@(posedge clk) disable iff (!rst_n)
        (adv_i && valid_i) |=> l1_o == $past(l1_i)); // R7
    end else begin : g_chk_l0
      AST_OTHER_L_PASS: assert property (@(posedge clk) disable iff (!rst_n)
        (adv_i && valid_i) |=> l0_o == $past(l0_i)); // R7
    end
    if (STEP >= 2) begin : g_chk_carry
      AST_S_CARRY: assert property (@(posedge clk) disable iff (!rst_n)
        (adv_i && valid_i) |=>
          s_o[(STEP-1)*WORD_W +: WORD_W] == $past(s_i[(STEP-1)*WORD_W +: WORD_W])); // R6
    end
  endgenerate

endmodule

// File: rtl/rc5_keysched_pass1.sv
`timescale 1ns/1ps
module rc5_keysched_pass1
  import rc5ks_pkg::*;
#(
  parameter int unsigned NUM_STEPS = 26
) (
  input  logic                        clk,
  input  logic                        rst_n,
  input  logic                        start_i,
  input  logic [KEY_W-1:0]            base_key_i,
  input  logic                        enable_i,
  input  logic                        stall_i,
  output logic                        valid_o,
  output logic [NUM_STEPS*WORD_W-1:0] s_words_o,
  output logic [WORD_W-1:0]           l0_o,
  output logic [WORD_W-1:0]           l1_o
);

  localparam int unsigned S_BITS = NUM_STEPS * WORD_W;

  logic [KEY_W-1:0] cur_key;
  logic             issue;
  logic             adv;

  logic              v_bus  [NUM_STEPS+1];
  logic [S_BITS-1:0] s_bus  [NUM_STEPS+1];
  word_t             l0_bus [NUM_STEPS+1];
  word_t             l1_bus [NUM_STEPS+1];

  assign adv = ~stall_i;

  rc5ks_key_ctr #(
    .CTR_W (KEY_W)
  ) u_ctr (
    .clk        (clk),
    .rst_n      (rst_n),
    .start_i    (start_i),
    .base_key_i (base_key_i),
    .enable_i   (enable_i),
    .stall_i    (stall_i),
    .key_o      (cur_key),
    .issue_o    (issue)
  );

  // Pipeline entry: key halves seed the L pair
  assign v_bus[0]  = issue;
  assign s_bus[0]  = '0;
  assign l0_bus[0] = cur_key[WORD_W-1:0];
  assign l1_bus[0] = cur_key[KEY_W-1:WORD_W];

  generate
    for (genvar k = 0; k < NUM_STEPS; k++) begin : g_stage
      rc5ks_mix_stage #(
        .STEP      (k),
        .NUM_STEPS (NUM_STEPS)
      ) u_stage (
        .clk     (clk),
        .rst_n   (rst_n),
        .adv_i   (adv),
        .valid_i (v_bus[k]),
        .s_i     (s_bus[k]),
        .l0_i    (l0_bus[k]),
        .l1_i    (l1_bus[k]),
        .valid_o (v_bus[k+1]),
        .s_o     (s_bus[k+1]),
        .l0_o    (l0_bus[k+1]),
        .l1_o    (l1_bus[k+1])
      );
    end
  endgenerate

  assign valid_o   = v_bus[NUM_STEPS];
  assign s_words_o = s_bus[NUM_STEPS];
  assign l0_o      = l0_bus[NUM_STEPS];
  assign l1_o      = l1_bus[NUM_STEPS];

  AST_S0_WIRED: assert property (@(posedge clk) disable iff (!rst_n)
    valid_o |-> s_words_o[WORD_W-1:0] == 32'hBF0A8B1D); // R5

  AST_START_NO_ISSUE: assert property (@(posedge clk) disable iff (!rst_n)
    (start_i && !stall_i) |=> !g_stage[0].u_stage.valid_o); // R2

endmodule

// File: tb/sim_rc5_keysched_pass1.sv
`timescale 1ns/1ps
module sim_rc5_keysched_pass1;

  localparam int NS = 26;
  localparam int OUT_W = NS * 32 + 64;

  logic           clk = 1'b0;
  logic           rst_n;
  logic           start_i;
  logic [63:0]    base_key_i;
  logic           enable_i;
  logic           stall_i;
  logic           valid_o;
  logic [NS*32-1:0] s_words_o;
  logic [31:0]    l0_o;
  logic [31:0]    l1_o;

  int tests = 0;
  int fails = 0;

  // Bench view of the pipeline contents, from the latency requirement
  logic        pv [NS];
  logic [63:0] pk [NS];
  logic [63:0] mcnt;

  always #2 clk = ~clk;

  rc5_keysched_pass1 #(.NUM_STEPS(NS)) u0 (
    .clk        (clk),
    .rst_n      (rst_n),
    .start_i    (start_i),
    .base_key_i (base_key_i),
    .enable_i   (enable_i),
    .stall_i    (stall_i),
    .valid_o    (valid_o),
    .s_words_o  (s_words_o),
    .l0_o       (l0_o),
    .l1_o       (l1_o)
  );

  function automatic logic [31:0] rot_left(input logic [31:0] x, input int n);
    if (n == 0) return x;
    return (x << n) | (x >> (32 - n));
  endfunction

  // Straight textbook loop: A, B registers and alternating L index
  function automatic logic [OUT_W-1:0] ref_pass(input logic [63:0] key);
    logic [31:0] a, b, t;
    logic [31:0] lw [2];
    logic [OUT_W-1:0] res;
    a = 0; b = 0;
    lw[0] = key[31:0];
    lw[1] = key[63:32];
    res = '0;
    for (int i = 0; i < NS; i++) begin
      t = 32'hB7E15163 + 32'(i) * 32'h9E3779B9;
      a = rot_left(t + a + b, 3);
      res[i*32 +: 32] = a;
      t = a + b;
      b = rot_left(lw[i % 2] + t, int'(t[4:0]));
      lw[i % 2] = b;
    end
    res[NS*32 +: 32]      = lw[0];
    res[NS*32 + 32 +: 32] = lw[1];
    return res;
  endfunction

  task automatic check(input string tag, input logic [63:0] got, input logic [63:0] exp);
    tests++;
    if (got !== exp) begin
      fails++;
      $display("FAIL %s: got %h expected %h", tag, got, exp);
    end
  endtask

  // One cycle: drive at negedge, model the edge, check at next negedge
  task automatic cyc(input logic st, input logic [63:0] bk, input logic en, input logic sl);
    logic [NS*32-1:0] ps;
    logic [31:0] p0, p1;
    logic pvld;
    logic [OUT_W-1:0] exp;
    ps = s_words_o; p0 = l0_o; p1 = l1_o; pvld = valid_o;
    start_i = st; base_key_i = bk; enable_i = en; stall_i = sl;
    @(posedge clk);
    if (!sl) begin
      for (int i = NS - 1; i > 0; i--) begin
        pv[i] = pv[i-1];
        pk[i] = pk[i-1];
      end
      pv[0] = en && !st;
      pk[0] = mcnt;
    end
    if (st) mcnt = bk;
    else if (en && !sl) mcnt = mcnt + 64'd1;
    @(negedge clk);
    check("R8 R10 valid timing", {63'd0, valid_o}, {63'd0, pv[NS-1]});
    if (sl) begin
      check("R9 stall holds S", {63'd0, (s_words_o == ps)}, 64'd1);
      check("R9 stall holds L/valid", {p0, p1}, {l0_o, l1_o});
      check("R9 stall holds valid", {63'd0, valid_o}, {63'd0, pvld});
    end
    if (valid_o && pv[NS-1]) begin
      exp = ref_pass(pk[NS-1]);
      check("R5 S word 0", {32'd0, s_words_o[31:0]}, {32'd0, exp[31:0]});
      for (int w = 1; w < NS; w++)
        check($sformatf("R6 R11 S word %0d", w), {32'd0, s_words_o[w*32 +: 32]},
              {32'd0, exp[w*32 +: 32]});
      check("R4 R7 final L pair", {l1_o, l0_o}, exp[NS*32 +: 64]);
    end
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    fails++;
    tests++;
    $display("FAIL watchdog: got timeout expected completion");
    $display("[TB] %0d tests run, %0d failed", tests, fails);
    $finish;
  end

  initial begin
    logic [63:0] rk;
    void'($urandom(32'd1234));
    for (int i = 0; i < NS; i++) begin pv[i] = 1'b0; pk[i] = '0; end
    mcnt = '0;
    rst_n = 1'b0; start_i = 0; base_key_i = '0; enable_i = 0; stall_i = 0;
    repeat (3) @(posedge clk);
    @(negedge clk);
    rst_n = 1'b1;
    // R1: nothing valid after reset
    check("R1 reset valid", {63'd0, valid_o}, 64'd0);
    for (int i = 0; i < 4; i++) cyc(0, '0, 0, 0);

    // R2 R4 all-zero key, one issue, then latency through bubbles (R8 R10)
    cyc(1, 64'd0, 1, 0);
    cyc(0, '0, 1, 0);
    for (int i = 0; i < NS + 3; i++) cyc(0, '0, 0, 0);

    // R3 wrap: all-ones base, three issues -> ffff..., 0, 1
    cyc(1, 64'hFFFF_FFFF_FFFF_FFFF, 1, 1);   // R2 start wins over stall
    for (int i = 0; i < 3; i++) cyc(0, '0, 1, 0);
    for (int i = 0; i < NS + 3; i++) cyc(0, '0, 0, 0);

    // R4: halves distinguishable
    cyc(1, 64'h0000_0001_FFFF_FFFE, 0, 0);
    cyc(0, '0, 1, 0);
    cyc(0, '0, 1, 1);
    cyc(0, '0, 1, 0);
    for (int i = 0; i < NS + 3; i++) cyc(0, '0, 0, 0);

    // Random traffic with stalls, gaps and restarts (R2 R3 R9 R10)
    rk = {$urandom(), $urandom()};
    cyc(1, rk, 1, 0);
    for (int i = 0; i < 800; i++) begin
      logic st, en, sl;
      st = ($urandom_range(99) < 2);
      en = ($urandom_range(99) < 80);
      sl = ($urandom_range(99) < 20);
      rk = {$urandom(), $urandom()};
      cyc(st, rk, en, sl);
    end
    for (int i = 0; i < NS + 3; i++) cyc(0, '0, 0, 0);

    $display("[TB] %0d tests run, %0d failed", tests, fails);
    $finish;
  end

endmodule